// File: doc/BRIEF.md
# Incremental Program Checksum Monitor

This block guards a user program held in RAM against silent corruption while the program runs. On request it reads the whole program area once, back to back, and keeps the 16-bit modular sum of those words as the reference. After that it works in the background. Each scan-cycle tick lets it read a small, fixed number of words and add them to a running sum, so the cost of the check is spread over many scans and no single scan pays for it all.

When the running sum covers the whole area, the block compares it with the reference. If the two agree, the running sum is cleared and the next tick starts a new pass at the base of the area. If they differ, the block stops the scan loop through a halt output and raises an error flag. Both stay set until reset. The memory port is a simple read port with one cycle of latency. The block always leaves a memory cycle idle between scan bursts.

The control state machine has these states:
- ST_IDLE: no reference exists yet.
- ST_REF_READ: the reference sweep is reading.
- ST_REF_SETTLE: waiting for the last read data to arrive.
- ST_REF_LATCH: the sum is stored as the reference.
- ST_RUN_WAIT: waiting for a scan tick.
- ST_RUN_READ: a scan burst is reading.
- ST_RUN_SETTLE: waiting for the last word of a pass.
- ST_COMPARE: the pass sum is compared with the reference.
- ST_HALT: a mismatch was found.

Its transitions are:
- ST_IDLE goes to ST_REF_READ on a reference request.
- ST_REF_READ goes to ST_REF_SETTLE, then to ST_REF_LATCH, then to ST_RUN_WAIT, after the last program word.
- ST_RUN_WAIT goes to ST_RUN_READ on a tick.
- ST_RUN_READ goes back to ST_RUN_WAIT when the burst budget is used.
- ST_RUN_READ goes to ST_RUN_SETTLE and then to ST_COMPARE when the last program word has been read.
- ST_COMPARE goes to ST_RUN_WAIT on a match and to ST_HALT on a mismatch.
- In every state except ST_HALT, a reference request returns the machine to ST_REF_READ.

Top module: `prog_csum_monitor`

## Requirements
- R1: While reset is held, and at its release, halt_scan and chk_err are 0 and mem_rd_en is 0. Reset clears a halt.
- R2: A ref_req seen at a clock edge, in any state but halted, starts a reference sweep. The sweep reads addresses PROG_BASE to PROG_BASE+PROG_LEN-1 in ascending order, one per cycle, from the next cycle on. The data returned one cycle after each read forms the 16-bit modulo-2^16 reference sum.
- R3: Before any reference has been taken, scan_tick causes no reads.
- R4: In run, each accepted scan_tick starts reads in the next cycle. It issues min(WORDS_PER_SCAN, words left in the pass) reads on consecutive cycles with ascending consecutive addresses.
- R5: After the last program word is read, the pointer wraps. The first read of the next pass is at PROG_BASE.
- R6: When the pass sum equals the reference modulo 2^16, nothing is flagged. The running sum restarts from zero, so later unchanged passes also match. Sums that overflow 16 bits wrap. A change that leaves the modular sum equal goes unflagged.
- R7: On a mismatch, halt_scan and chk_err both rise together, three cycles after the cycle in which the last read of the pass is issued.
- R8: Once set, halt_scan and chk_err stay at 1 until reset. While halted, no read is issued, and both scan_tick and ref_req are ignored.
- R9: A ref_req during a run burst abandons the partial pass. Data already in flight is discarded, and a new reference sweep starts from PROG_BASE.
- R10: A scan_tick that arrives while a burst, a sweep or a compare is in progress is ignored. It neither lengthens nor repeats the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Request a reference sweep (one-cycle pulse) |
| scan_tick | input | 1 | Start of a scan cycle (one-cycle pulse) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after mem_rd_en |
| halt_scan | output | 1 | Stop the scan loop (sticky) |
| chk_err | output | 1 | Checksum mismatch flag (sticky) |

## Verification
A pointer that skips, repeats or fails to wrap shows at once on mem_rd_addr. It also shows as a wrong read count in the very next burst. An accumulator that keeps stale data is different: it drops a captured word, does not clear between passes, or keeps in-flight data across a restart. Its only visible symptom is a false halt, and that halt appears exactly three cycles after the final read of the pass in which the error arose. The bench therefore runs unchanged passes after each kind of event and times every expected halt against the last read.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Control states of the checksum monitor
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REF_READ,
        ST_REF_SETTLE,
        ST_REF_LATCH,
        ST_RUN_WAIT,
        ST_RUN_READ,
        ST_RUN_SETTLE,
        ST_COMPARE,
        ST_HALT
    } pcm_state_e;

    // Width of an index able to hold 0..n-1, never below one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pcm_addr_gen.sv
// Program pointer and per-burst read counter
module pcm_addr_gen
    import pcm_pkg::*;
#(
    parameter int unsigned ADDR_W         = 16,
    parameter int unsigned PROG_BASE      = 0,
    parameter int unsigned PROG_LEN       = 1024,
    parameter int unsigned WORDS_PER_SCAN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_rst,
    input  logic              burst_start,
    input  logic              adv,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              last_word,
    output logic              burst_last
);

    localparam int unsigned IDX_W = idx_width(PROG_LEN);
    localparam int unsigned BCW   = idx_width(WORDS_PER_SCAN);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(PROG_LEN - 1);
    localparam logic [BCW-1:0]    BC_LAST  = BCW'(WORDS_PER_SCAN - 1);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(PROG_BASE);

    logic [IDX_W-1:0] idx_q;
    logic [BCW-1:0]   bcnt_q;

    assign last_word  = (idx_q == IDX_LAST);
    assign burst_last = (bcnt_q == BC_LAST);
    assign rd_addr    = BASE_A + ADDR_W'(idx_q);

    // Word index inside the program area, wraps after the last word
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_rst) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= last_word ? '0 : idx_q + 1'b1;
        end
    end

    // Reads issued in the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_rst || burst_start) begin
            bcnt_q <= '0;
        end else if (adv) begin
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pcm_accum.sv
// Modular sum of returned read data, one cycle behind the read strobe
module pcm_accum #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sum
);

    logic data_due_q;

    // A clear also drops the word whose read is still in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_due_q <= 1'b0;
        end else begin
            data_due_q <= rd_fire && !clr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
        end else if (data_due_q) begin
            sum <= sum + rd_data;
        end
    end

endmodule

// File: rtl/pcm_ctrl.sv
// Sequencing of reference sweep, scan bursts and compare
module pcm_ctrl
    import pcm_pkg::*;
#(
    parameter int unsigned SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_req,
    input  logic             scan_tick,
    input  logic             last_word,
    input  logic             burst_last,
    input  logic [SUM_W-1:0] run_sum,
    output logic             rd_en,
    output logic             ptr_rst,
    output logic             burst_start,
    output logic             acc_clr,
    output logic             halt_scan,
    output logic             chk_err
);

    pcm_state_e       state_q, state_d;
    logic [SUM_W-1:0] ref_q;
    logic             err_q;
    logic             restart;
    logic             sums_differ;

    assign restart     = ref_req && (state_q != ST_HALT);
    assign sums_differ = (run_sum != ref_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req) state_d = ST_REF_READ;
            end
            ST_REF_READ: begin
                if (ref_req)        state_d = ST_REF_READ;
                else if (last_word) state_d = ST_REF_SETTLE;
            end
            ST_REF_SETTLE: begin
                state_d = ref_req ? ST_REF_READ : ST_REF_LATCH;
            end
            ST_REF_LATCH: begin
                state_d = ref_req ? ST_REF_READ : ST_RUN_WAIT;
            end
            ST_RUN_WAIT: begin
                if (ref_req)        state_d = ST_REF_READ;
                else if (scan_tick) state_d = ST_RUN_READ;
            end
            ST_RUN_READ: begin
                if (ref_req)         state_d = ST_REF_READ;
                else if (last_word)  state_d = ST_RUN_SETTLE;
                else if (burst_last) state_d = ST_RUN_WAIT;
            end
            ST_RUN_SETTLE: begin
                state_d = ref_req ? ST_REF_READ : ST_COMPARE;
            end
            ST_COMPARE: begin
                if (ref_req)          state_d = ST_REF_READ;
                else if (sums_differ) state_d = ST_HALT;
                else                  state_d = ST_RUN_WAIT;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        rd_en       = (state_q == ST_REF_READ) || (state_q == ST_RUN_READ);
        ptr_rst     = restart;
        burst_start = (state_q == ST_RUN_WAIT) && scan_tick && !ref_req;
        acc_clr     = restart || (state_q == ST_REF_LATCH) || (state_q == ST_COMPARE);
        halt_scan   = (state_q == ST_HALT);
        chk_err     = err_q;
    end

    // Reference sum, taken once the last sweep word has landed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if ((state_q == ST_REF_LATCH) && !ref_req) begin
            ref_q <= run_sum;
        end
    end

    // Sticky error flag, set by a failing compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((state_q == ST_COMPARE) && !ref_req && sums_differ) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/prog_csum_monitor.sv
module prog_csum_monitor #(
    parameter int unsigned ADDR_W         = 16,
    parameter int unsigned DATA_W         = 16,
    parameter int unsigned PROG_BASE      = 0,
    parameter int unsigned PROG_LEN       = 1024,
    parameter int unsigned WORDS_PER_SCAN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_req,
    input  logic              scan_tick,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              halt_scan,
    output logic              chk_err
);

    logic              ptr_rst;
    logic              burst_start;
    logic              acc_clr;
    logic              last_word;
    logic              burst_last;
    logic              rd_en;
    logic [DATA_W-1:0] run_sum;

    assign mem_rd_en = rd_en;

    pcm_ctrl #(
        .SUM_W(DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_req    (ref_req),
        .scan_tick  (scan_tick),
        .last_word  (last_word),
        .burst_last (burst_last),
        .run_sum    (run_sum),
        .rd_en      (rd_en),
        .ptr_rst    (ptr_rst),
        .burst_start(burst_start),
        .acc_clr    (acc_clr),
        .halt_scan  (halt_scan),
        .chk_err    (chk_err)
    );

    pcm_addr_gen #(
        .ADDR_W        (ADDR_W),
        .PROG_BASE     (PROG_BASE),
        .PROG_LEN      (PROG_LEN),
        .WORDS_PER_SCAN(WORDS_PER_SCAN)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_rst    (ptr_rst),
        .burst_start(burst_start),
        .adv        (rd_en),
        .rd_addr    (mem_rd_addr),
        .last_word  (last_word),
        .burst_last (burst_last)
    );

    pcm_accum #(
        .DATA_W(DATA_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .rd_fire(rd_en),
        .rd_data(mem_rd_data),
        .sum    (run_sum)
    );

endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PROG_BASE = 0,
    parameter int unsigned PROG_LEN  = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_req,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              halt_scan,
    input logic              chk_err
);

    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(PROG_BASE);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(PROG_BASE + PROG_LEN - 1);

    assert_err_with_halt_R7: assert property (
        @(posedge clk) disable iff (!rst_n) halt_scan == chk_err);

    assert_halt_sticky_R8: assert property (
        @(posedge clk) disable iff (!rst_n) halt_scan |=> halt_scan);

    assert_no_read_halted_R8: assert property (
        @(posedge clk) disable iff (!rst_n) halt_scan |-> !mem_rd_en);

    assert_addr_in_area_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr >= FIRST_A) && (mem_rd_addr <= LAST_A));

    assert_addr_step_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en) && !$past(ref_req)) |->
        (mem_rd_addr == (($past(mem_rd_addr) == LAST_A) ? FIRST_A
                                                        : $past(mem_rd_addr) + 1'b1)));

endmodule

bind prog_csum_monitor pcm_checker #(
    .ADDR_W   (ADDR_W),
    .PROG_BASE(PROG_BASE),
    .PROG_LEN (PROG_LEN)
) u_pcm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .halt_scan  (halt_scan),
    .chk_err    (chk_err)
);

// File: tb/tb_prog_csum_monitor.sv
module tb_prog_csum_monitor;

    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int BASE = 'h0200;
    localparam int LEN  = 61;
    localparam int WPS  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_req = 1'b0;
    logic          scan_tick = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          halt_scan;
    logic          chk_err;

    logic [DW-1:0] mem [LEN];

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int addr_err = 0;
    int exp_idx = 0;
    int first_addr = 0;
    int pos = 0;
    int cyc = 0;
    int last_rd_cyc = 0;
    int halt_cyc = 0;
    bit halt_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prog_csum_monitor #(
        .ADDR_W(AW), .DATA_W(DW), .PROG_BASE(BASE),
        .PROG_LEN(LEN), .WORDS_PER_SCAN(WPS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .scan_tick(scan_tick),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .halt_scan(halt_scan), .chk_err(chk_err)
    );

    // Memory model: one cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            if (int'(mem_rd_addr) >= BASE && int'(mem_rd_addr) < BASE + LEN)
                mem_rd_data <= mem[int'(mem_rd_addr) - BASE];
            else
                mem_rd_data <= 'x;
        end
    end

    // Read and halt monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (mem_rd_en) begin
            if (rd_cnt == 0) first_addr = int'(mem_rd_addr);
            if (int'(mem_rd_addr) != BASE + exp_idx) addr_err++;
            exp_idx = (exp_idx == LEN - 1) ? 0 : exp_idx + 1;
            rd_cnt++;
            last_rd_cyc = cyc;
        end
        if (halt_scan && !halt_seen) begin
            halt_seen = 1;
            halt_cyc = cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int burst_len(input int p);
        return (LEN - p < WPS) ? LEN - p : WPS;
    endfunction

    task automatic fill_random();
        for (int i = 0; i < LEN; i++) mem[i] = DW'($urandom());
    endtask

    task automatic clear_counts();
        rd_cnt = 0;
        addr_err = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 halt in reset", halt_scan, 0);
        check("R1 err in reset", chk_err, 0);
        check("R1 no read in reset", mem_rd_en, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 halt after reset", halt_scan, 0);
        check("R1 read idle after reset", mem_rd_en, 0);
        halt_seen = 0;
        pos = 0;
        exp_idx = 0;
    endtask

    task automatic do_ref(input bit halted, input string req);
        @(posedge clk); #1 ref_req = 1'b1;
        @(posedge clk); #1 ref_req = 1'b0;
        clear_counts();
        exp_idx = 0;
        repeat (LEN + 6) @(posedge clk);
        #1;
        check({req, " sweep read count"}, rd_cnt, halted ? 0 : LEN);
        check({req, " sweep addresses"}, addr_err, 0);
        if (!halted) pos = 0;
    endtask

    task automatic tick_once(input bit halted);
        int exp_n;
        exp_n = halted ? 0 : burst_len(pos);
        @(posedge clk); #1;
        clear_counts();
        scan_tick = 1'b1;
        @(posedge clk); #1 scan_tick = 1'b0;
        repeat (WPS + 6) @(posedge clk);
        #1;
        check(halted ? "R8 reads while halted" : "R4 reads per tick", rd_cnt, exp_n);
        check("R4 burst addresses", addr_err, 0);
        if (!halted && pos == 0) check("R5 pass starts at base", first_addr, BASE);
        if (!halted) pos = (pos + exp_n == LEN) ? 0 : pos + exp_n;
    endtask

    // One full pass from the current position to the wrap
    task automatic run_pass(input bit expect_halt, input string req);
        bit ended;
        ended = 0;
        while (!ended) begin
            tick_once(0);
            ended = (pos == 0);
            if (!ended) check({req, " no halt mid-pass"}, halt_scan, 0);
        end
        check({req, " halt at pass end"}, halt_scan, expect_halt ? 1 : 0);
        check({req, " err at pass end"}, chk_err, expect_halt ? 1 : 0);
        if (expect_halt) check("R7 halt latency", halt_cyc - last_rd_cyc, 3);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_C0DE);
        for (int i = 0; i < LEN; i++) mem[i] = '0;
        do_reset();

        // R3: ticks before any reference
        fill_random();
        tick_once(1);
        check("R3 no halt before reference", halt_scan, 0);

        // R2, R4, R5, R6: reference then unchanged passes
        do_ref(0, "R2");
        run_pass(0, "R6 first pass");
        run_pass(0, "R6 second pass");

        // R6: 16-bit overflow wraps
        for (int i = 0; i < LEN; i++) mem[i] = 16'hFFFF;
        do_ref(0, "R2 all-ones");
        run_pass(0, "R6 overflow");

        // R6: compensating change keeps the modular sum
        fill_random();
        do_ref(0, "R2 random");
        mem[5]  = mem[5] + 16'h1234;
        mem[40] = mem[40] - 16'h1234;
        run_pass(0, "R6 equal-sum change");

        // R10: second tick during a burst is ignored
        @(posedge clk); #1;
        clear_counts();
        scan_tick = 1'b1;
        @(posedge clk); #1 scan_tick = 1'b0;
        repeat (3) @(posedge clk);
        #1 scan_tick = 1'b1;
        @(posedge clk); #1 scan_tick = 1'b0;
        repeat (WPS + 6) @(posedge clk);
        #1 check("R10 tick during burst ignored", rd_cnt, WPS);
        pos = WPS;
        run_pass(0, "R10 rest of pass");

        // R9: reference request inside a run burst
        @(posedge clk); #1 scan_tick = 1'b1;
        @(posedge clk); #1 scan_tick = 1'b0;
        repeat (5) @(posedge clk);
        #1 mem[2] = mem[2] ^ 16'h00F0;
        do_ref(0, "R9 restart");
        run_pass(0, "R9 after restart");
        run_pass(0, "R9 second pass");

        // R7, R8: corruption detected and sticky
        mem[LEN-1] = mem[LEN-1] ^ 16'h8001;
        run_pass(1, "R7 corrupted");
        tick_once(1);
        do_ref(1, "R8 ref ignored when halted");
        check("R8 halt held", halt_scan, 1);
        check("R8 err held", chk_err, 1);

        // Random rounds
        for (int r = 0; r < 4; r++) begin
            int k;
            logic [15:0] x;
            do_reset();
            fill_random();
            do_ref(0, "R2 round");
            run_pass(0, "R6 round clean");
            k = $urandom_range(LEN - 1);
            x = DW'($urandom_range(16'hFFFF, 1));
            mem[k] = mem[k] ^ x;
            run_pass(1, "R7 round corrupted");
        end

        do_reset();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule